// File: doc/BRIEF.md
# Double-Buffered Segmented DAC Front End

This block is the digital side of a segmented current-output DAC. A parallel code word arrives on a data bus together with an active-low write strobe and an active-high load control. Two registers sit in series: a capture register that takes the bus while the strobe is low, and a conversion register that drives the analog switches and copies the capture register while load is high. Each stage is controlled by a level, so driving the strobe low with load high makes both stages transparent from bus to output. The double buffering lets several converters be written one at a time and then updated together from a shared load line.

The conversion register is presented in two forms. The top four bits become fifteen equal-weight segment enables in thermometer form, each worth one sixteenth of full scale. The remaining low bits go out in plain binary to the fine ladder. That is 12 bits at the default 16-bit width, or 10 bits when the width parameter is 14. An active-low reset clears both registers to zero scale, or to midscale when the level-select input is high. It acts at once and overrides every other control. Strobe, load, reset release and data are brought into the system clock through two-flop synchronizers.

Top module: `seg_dac_frontend`

## Requirements
- R1: While the synchronized strobe is low and reset is inactive, the capture register follows the data bus.
- R2: With strobe low and load low, only the capture register loads. The conversion register, and so both outputs, keep their value.
- R3: With strobe high and load high, the conversion register takes the capture register's contents.
- R4: With strobe low and load high, both registers are transparent, and the outputs show the data bus.
- R5: With strobe high and load low, neither register changes, whatever the data bus does.
- R6: Driving reset low sets both registers at once, with no clock edge needed. They go to all zeros when the level select is 0, and to only the top bit set (0x8000 at 16 bits) when it is 1.
- R7: Reset is released synchronously. For the first two rising edges after release the registers keep the reset value. A control already present is applied on the third edge.
- R8: The capture register holds the word present just before the strobe's rising edge. When strobe and load are one shared signal, a low pulse loads the capture register only, and its rising edge moves that word into the conversion register.
- R9: A stable change on the bus or controls reaches the outputs on the third rising clock edge after it is applied, and not earlier.
- R10: Segment enable k (bit k-1 of the segment output, k = 1..15) is on exactly when the top four bits of the conversion register, read as an unsigned value, are at least k. Value 0 gives all enables off, and value 15 gives all on.
- R11: The low output equals the conversion register's low DATA_W-4 bits. The count of enabled segments times 2^(DATA_W-4), plus the low output, rebuilds the conversion register value D.
- R12: The rebuilt code D gives an ideal unipolar output of D/2^N and a bipolar output of D/2^(N-1) - 1, in units of the reference, with N = DATA_W. The midscale reset gives 0.5 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset: asynchronous assert, synchronized release |
| mid_sel | input | 1 | Reset level select: 0 gives zero scale, 1 gives midscale |
| wr_n | input | 1 | Active-low write strobe for the capture register |
| load_en | input | 1 | Active-high load of the conversion register |
| data_in | input | DATA_W | Parallel code word |
| seg_on | output | 15 | Thermometer enables for the fifteen coarse segments |
| lsb_bits | output | DATA_W-4 | Binary low bits for the fine ladder |

## Verification
Each change on the bus or the controls reaches the outputs on the third rising edge after it is applied: two synchronizer flops, then the register stage. The bench drives on falling edges, holds each stimulus for three rising edges, and samples on the next falling edge. The latency case also samples after only two edges, where the old value must still show. Reset assertion is checked a few nanoseconds after reset falls, with no clock edge in between. Reset release is checked after two edges, where the reset value must remain, and again after the third edge, where the pending control must have acted.

// File: rtl/segdac_pkg.sv
package segdac_pkg;

    // Width of the coarse field decoded into thermometer segments
    localparam int SEG_MSB_W = 4;
    localparam int SEG_N     = (1 << SEG_MSB_W) - 1;

    // What the two register stages do for a given pair of control levels
    typedef enum logic [1:0] {
        MODE_HOLD    = 2'd0,   // strobe high, load low
        MODE_CAPTURE = 2'd1,   // strobe low,  load low
        MODE_UPDATE  = 2'd2,   // strobe high, load high
        MODE_FLOW    = 2'd3    // strobe low,  load high
    } wmode_e;

    function automatic wmode_e pick_mode(input logic wr_lvl_n, input logic ld_lvl);
        wmode_e m;
        unique case ({wr_lvl_n, ld_lvl})
            2'b00:   m = MODE_CAPTURE;
            2'b01:   m = MODE_FLOW;
            2'b10:   m = MODE_HOLD;
            default: m = MODE_UPDATE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/segdac_sync.sv
module segdac_sync #(
    parameter int           W      = 1,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] INIT   = '0
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= {STAGES{INIT}};
        else         chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/segdac_regs.sv
module segdac_regs
    import segdac_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,     // synchronized-release reset
    input  logic          mid_sel,
    input  logic          wr_n_s,
    input  logic          ld_s,
    input  logic [DW-1:0] bus_s,
    output logic [DW-1:0] dac_code
);

    typedef struct packed {
        logic [DW-1:0] in_w;
        logic [DW-1:0] dac_w;
        logic          wr_prev;
    } st_t;

    st_t           st_d, st_q;
    st_t           st_rst;
    logic [DW-1:0] rst_word;
    logic          wr_rise;

    assign rst_word = mid_sel ? {1'b1, {(DW-1){1'b0}}} : '0;
    assign st_rst   = '{in_w: rst_word, dac_w: rst_word, wr_prev: 1'b1};
    assign wr_rise  = wr_n_s & ~st_q.wr_prev;

    always_comb begin
        st_d         = st_q;
        st_d.wr_prev = wr_n_s;
        unique case (pick_mode(wr_n_s, ld_s))
            MODE_CAPTURE: st_d.in_w = bus_s;
            MODE_FLOW: begin
                st_d.in_w  = bus_s;
                st_d.dac_w = bus_s;
            end
            MODE_UPDATE:  st_d.dac_w = st_q.in_w;
            default:      ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    assign dac_code = st_q.dac_w;

    // R1
    in_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_s |=> st_q.in_w == $past(bus_s));

    // R2
    capture_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n_s && !ld_s) |=> $stable(st_q.dac_w));

    // R3
    update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_n_s && ld_s) |=> st_q.dac_w == $past(st_q.in_w));

    // R4
    flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n_s && ld_s) |=> st_q.dac_w == $past(bus_s));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_n_s && !ld_s) |=> ($stable(st_q.in_w) && $stable(st_q.dac_w)));

    // R8
    rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rise |-> st_q.in_w == $past(bus_s));

endmodule

// File: rtl/segdac_therm.sv
module segdac_therm #(
    parameter  int MW    = 4,
    localparam int SEG_N = (1 << MW) - 1
) (
    input  logic [MW-1:0]    level,
    output logic [SEG_N-1:0] seg
);

    for (genvar k = 1; k <= SEG_N; k++) begin : g_seg
        assign seg[k-1] = (int'(level) >= k);
    end

endmodule

// File: rtl/seg_dac_frontend.sv
module seg_dac_frontend
    import segdac_pkg::*;
#(
    parameter  int DATA_W = 16,
    localparam int MSB_W  = SEG_MSB_W,
    localparam int NSEG   = SEG_N,
    localparam int LSB_W  = DATA_W - MSB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mid_sel,
    input  logic              wr_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] data_in,
    output logic [NSEG-1:0]   seg_on,
    output logic [LSB_W-1:0]  lsb_bits
);

    logic              rst_int_n;
    logic [1:0]        ctl_s;
    logic [DATA_W-1:0] bus_s;
    logic [DATA_W-1:0] dac_code;

    segdac_sync #(.W(1), .STAGES(2), .INIT(1'b0)) u_rst_sync (
        .clk(clk), .arst_n(rst_n), .d(1'b1), .q(rst_int_n)
    );

    // strobe idles high, load idles low
    segdac_sync #(.W(2), .STAGES(2), .INIT(2'b10)) u_ctl_sync (
        .clk(clk), .arst_n(rst_n), .d({wr_n, load_en}), .q(ctl_s)
    );

    // data delayed alongside the controls so they stay aligned
    segdac_sync #(.W(DATA_W), .STAGES(2), .INIT('0)) u_bus_sync (
        .clk(clk), .arst_n(rst_n), .d(data_in), .q(bus_s)
    );

    segdac_regs #(.DW(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_int_n), .mid_sel(mid_sel),
        .wr_n_s(ctl_s[1]), .ld_s(ctl_s[0]), .bus_s(bus_s),
        .dac_code(dac_code)
    );

    segdac_therm #(.MW(MSB_W)) u_therm (
        .level(dac_code[DATA_W-1 -: MSB_W]), .seg(seg_on)
    );

    assign lsb_bits = dac_code[LSB_W-1:0];

    // R10
    seg_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seg_on) == int'(dac_code[DATA_W-1 -: MSB_W]));

    // R10
    seg_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((seg_on + 1'b1) & seg_on) == '0);

endmodule

// File: tb/seg_dac_frontend_test.sv
module seg_dac_frontend_test;

    localparam int DW = 16;
    localparam int LW = DW - 4;

    logic          clk = 1'b0;
    logic          rst_n, mid_sel, wr_n, load_en;
    logic [DW-1:0] data_in;
    logic [14:0]   seg_on;
    logic [LW-1:0] lsb_bits;

    int            n_checks = 0;
    int            n_fail   = 0;
    logic [DW-1:0] m_in, m_dac;

    always #10 clk = ~clk;

    seg_dac_frontend #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .mid_sel(mid_sel), .wr_n(wr_n),
        .load_en(load_en), .data_in(data_in), .seg_on(seg_on), .lsb_bits(lsb_bits)
    );

    function automatic logic [14:0] therm_exp(input logic [3:0] v);
        logic [14:0] r;
        for (int k = 1; k <= 15; k++) r[k-1] = (int'(v) >= k);
        return r;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // outputs against a given expected conversion value
    task automatic check_out(input string tag, input logic [DW-1:0] exp);
        longint d_seen;
        real    uni_s, uni_e, bip_s, bip_e;
        chk({tag, " R10 segments"}, seg_on, therm_exp(exp[DW-1 -: 4]));
        chk({tag, " R11 low bits"}, lsb_bits, exp[LW-1:0]);
        d_seen = longint'($countones(seg_on)) * (64'd1 << LW) + longint'(lsb_bits);
        chk({tag, " R11 rebuilt"}, d_seen, exp);
        uni_s = real'(d_seen) / real'(64'd1 << DW);
        uni_e = real'(exp) / 65536.0;
        bip_s = real'(d_seen) / real'(64'd1 << (DW - 1)) - 1.0;
        bip_e = real'(exp) / 32768.0 - 1.0;
        chk({tag, " R12 unipolar"}, $rtoi(uni_s * 1048576.0), $rtoi(uni_e * 1048576.0));
        chk({tag, " R12 bipolar"}, $rtoi(bip_s * 1048576.0), $rtoi(bip_e * 1048576.0));
    endtask

    // apply a control pair, hold for three rising edges, update the model
    task automatic step(input logic w, input logic l, input logic [DW-1:0] d);
        @(negedge clk);
        wr_n = w; load_en = l; data_in = d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (!w) begin
            m_in = d;
            if (l) m_dac = d;
        end else if (l) begin
            m_dac = m_in;
        end
    endtask

    task automatic do_reset(input logic ms, input logic [DW-1:0] pend);
        logic [DW-1:0] rw;
        rw = ms ? 16'h8000 : 16'h0000;
        @(negedge clk);
        #3;
        mid_sel = ms;
        rst_n   = 1'b0;
        #2;
        check_out("R6 immediate reset", rw);
        if (ms) chk("R12 midscale bipolar zero", longint'($countones(seg_on)), 8);
        repeat (2) @(posedge clk);
        @(negedge clk);
        wr_n = 1'b0; load_en = 1'b1; data_in = pend;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_out("R7 held after release", rw);
        @(posedge clk);
        @(negedge clk);
        check_out("R7 first update", pend);
        m_in = pend; m_dac = pend;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int seed;
        seed    = $urandom(32'h1A2B);
        rst_n   = 1'b0;
        mid_sel = 1'b0;
        wr_n    = 1'b1;
        load_en = 1'b0;
        data_in = '0;
        m_in    = '0;
        m_dac   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_out("R6 reset zero scale", 16'h0000);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);

        // R4 transparent, thermometer corners (R10)
        step(1'b0, 1'b1, 16'h0000); check_out("R4 zero", m_dac);
        step(1'b0, 1'b1, 16'hFFFF); check_out("R4 full", m_dac);
        step(1'b0, 1'b1, 16'h0FFF); check_out("R10 top zero", m_dac);
        step(1'b0, 1'b1, 16'h1000); check_out("R10 one segment", m_dac);
        step(1'b0, 1'b1, 16'hF000); check_out("R10 all segments", m_dac);
        chk("R10 all on", seg_on, 15'h7FFF);

        // R2 capture only, then R3 update brings the captured word out
        step(1'b0, 1'b0, 16'h3A5C); check_out("R2 dac held", 16'hF000);
        step(1'b1, 1'b1, 16'h0000); check_out("R3 update", 16'h3A5C);

        // R5 idle: bus changes ignored, then load shows capture unchanged
        step(1'b0, 1'b0, 16'h7777);
        step(1'b1, 1'b0, 16'hBEEF); check_out("R5 dac held", 16'h3A5C);
        step(1'b1, 1'b1, 16'h1234); check_out("R5 capture held", 16'h7777);

        // R9 latency: old value after two edges, new after three
        @(negedge clk);
        wr_n = 1'b0; load_en = 1'b1; data_in = 16'hC0DE;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_out("R9 not yet", 16'h7777);
        @(posedge clk);
        @(negedge clk);
        check_out("R9 due", 16'hC0DE);
        m_in = 16'hC0DE; m_dac = 16'hC0DE;

        // R8 strobe and load tied: low pulse captures, rising edge updates
        step(1'b0, 1'b0, 16'h5A5A); check_out("R8 pulse low", 16'hC0DE);
        @(negedge clk);
        wr_n = 1'b1; load_en = 1'b1; data_in = 16'h0F0F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_out("R8 rising edge", 16'h5A5A);
        m_dac = 16'h5A5A;

        // R6/R7 midscale and zero-scale reset
        do_reset(1'b1, 16'h9ABC);
        do_reset(1'b0, 16'h4321);

        // R1 random mix against the model
        for (int i = 0; i < 400; i++) begin
            logic [1:0]    sel;
            logic [DW-1:0] dv;
            sel = 2'($urandom_range(0, 3));
            dv  = DW'($urandom());
            if ($urandom_range(0, 39) == 0) begin
                do_reset(1'($urandom_range(0, 1)), dv);
            end else begin
                step(sel[1], sel[0], dv);
                check_out("R1 random", m_dac);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule